// File: doc/BRIEF.md
# Multi-Size Data Translation Lookaside Buffer

This block is a fully associative data-side translation buffer. It holds a parameterised number of entries, 64 by default. Each entry pairs a tag with a translation record. The tag is a virtual page number and a 13-bit context. The record holds a valid flag, a global flag, a page-size code, access restrictions and a physical page number. Each entry has its own page size, so the part of the virtual address that is compared changes from entry to entry.

A lookup carries a virtual address, an access kind, a context selector, a user flag and the current privileged-mode flag. It produces a 41-bit physical address when the lookup succeeds. Otherwise it classifies the outcome as a miss, a data fault or a write-protection fault. Faults and misses load the fault-status, fault-address and tag-access registers that trap handlers read.

Entries are installed through a separate write port. Choosing a victim and walking the page tables are left to the surrounding logic.

Top module: `mstlb_top`

## Requirements
- R1: An entry with size code s covers a page of 8 KB × 8^s (s = 0, 1, 2, 3 gives 8 KB, 64 KB, 512 KB, 4 MB). Only virtual address bits [63:13+3s] are compared with the tag.
- R2: An entry matches only if it is valid and its page compares equal, and only if it is global or its context equals the lookup context. The lookup context is taken from the selector: 0 picks `primary_ctx`, 1 picks `secondary_ctx`, and 2 or 3 picks the nucleus context 0.
- R3: On a successful lookup, `rsp_pa` bits [40:13+3s] come from the entry's physical page number and bits [12+3s:13] come from the virtual address. Bits [12:0] are zero. On any other outcome `rsp_pa` is zero.
- R4: When several entries match, the entry with the lowest index is used.
- R5: A user lookup (`req_user`=1) that matches a privileged entry is a data fault and sets status bit 7.
- R6: A non-faulting load (kind 2) that matches a side-effect entry sets status bit 8. Any other kind (0 load, 1 store) that matches a no-fault-only entry sets status bit 9. These bits and bit 7 can be set together, and any of them gives `rsp_dfault`.
- R7: A store (kind 1) to a non-writable entry gives `rsp_prot`, but only when no data fault applies.
- R8: On a successful lookup, `rsp_writable` shows the entry's writable flag. `rsp_first_use` is 1 only if the entry's used mark was clear before the lookup. The lookup sets the mark, and installing an entry clears it.
- R9: On a data or protection fault, `fault_status` is rebuilt as follows: bit 0 is set to 1 (valid), bit 1 is the previous bit 0 (overflow), bit 2 is the store flag, bit 3 is the non-faulting-load flag, bits [5:4] are the context type (0 primary, 1 secondary, 2 nucleus), bit 6 is `req_priv_mode`, and bits [9:7] are the fault causes. `fault_addr` is loaded with the full virtual address.
- R10: On a fault or a miss, `tag_access` is loaded with virtual address bits [63:13] above the 13-bit lookup context.
- R11: A lookup that matches nothing gives `rsp_miss` and leaves `fault_status` and `fault_addr` unchanged.
- R12: Each accepted request gives exactly one response with `rsp_valid` high one clock later. Reset clears all entries and sets every output register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Install the entry below |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 51 | Tag virtual page, address bits [63:13] |
| wr_ctx | input | 13 | Tag context |
| wr_valid | input | 1 | Entry valid |
| wr_global | input | 1 | Match in every context |
| wr_size | input | 2 | Page size code |
| wr_priv | input | 1 | Privileged-only page |
| wr_writable | input | 1 | Stores allowed |
| wr_side_effect | input | 1 | Page has side effects |
| wr_nofault_only | input | 1 | Only non-faulting loads allowed |
| wr_ppn | input | 28 | Physical page, address bits [40:13] |
| primary_ctx | input | 13 | Primary context value |
| secondary_ctx | input | 13 | Secondary context value |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 non-faulting load |
| req_ctx_sel | input | 2 | Context selector |
| req_user | input | 1 | Access made in user mode |
| req_priv_mode | input | 1 | Privileged mode flag recorded on a fault |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_dfault | output | 1 | Data fault |
| rsp_prot | output | 1 | Write-protection fault |
| rsp_pa | output | 41 | Physical address |
| rsp_writable | output | 1 | Write right granted |
| rsp_first_use | output | 1 | First successful use since install |
| fault_status | output | 10 | Fault status register |
| fault_addr | output | 64 | Fault address register |
| tag_access | output | 64 | Tag-access register |

## Verification
The assertions assume that a write and a lookup that hits the same index never occur in the same cycle. The stimulus installs every entry before looking it up and keeps writes and lookups in separate cycles. The index checks also assume that `wr_idx` is below the entry count. All 64 index values are legal at the default size, and the bench uses only indices inside that range. The stimulus deliberately places two global entries over the same page so that the lowest-index rule is exercised. Apart from that one case, it keeps pages apart so that each lookup has only one possible matching entry.

// File: rtl/mstlb_pkg.sv
package mstlb_pkg;

    localparam int VA_W     = 64;
    localparam int PA_W     = 41;
    localparam int CTX_W    = 13;
    localparam int PG_SHIFT = 13;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PPN_W    = PA_W - PG_SHIFT;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'd0,
        ACC_STORE  = 2'd1,
        ACC_NFLOAD = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        CT_PRIMARY   = 2'd0,
        CT_SECONDARY = 2'd1,
        CT_NUCLEUS   = 2'd2
    } ctx_type_e;

    typedef enum logic [1:0] {
        RES_HIT    = 2'd0,
        RES_MISS   = 2'd1,
        RES_DFAULT = 2'd2,
        RES_PROT   = 2'd3
    } res_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [CTX_W-1:0] ctx;
    } tag_t;

    typedef struct packed {
        logic             valid;
        logic             global;
        logic [1:0]       size;
        logic             priv;
        logic             writable;
        logic             side_eff;
        logic             nfo;
        logic [PPN_W-1:0] ppn;
    } tte_t;

    typedef struct packed {
        logic nfo_f;
        logic nfe_f;
        logic priv_f;
    } flt_t;

    typedef struct packed {
        logic       nfo_f;
        logic       nfe_f;
        logic       priv_f;
        logic       priv_mode;
        logic [1:0] ctx_type;
        logic       nf;
        logic       wr;
        logic       ovf;
        logic       valid;
    } fsr_t;

    function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] sz);
        return {VPN_W{1'b1}} << (3 * sz);
    endfunction

    function automatic logic [PPN_W-1:0] ppn_mask(input logic [1:0] sz);
        return {PPN_W{1'b1}} << (3 * sz);
    endfunction

    function automatic ctx_type_e sel_to_type(input logic [1:0] sel);
        case (sel)
            2'd0:    return CT_PRIMARY;
            2'd1:    return CT_SECONDARY;
            default: return CT_NUCLEUS;
        endcase
    endfunction

endpackage

// File: rtl/mstlb_store.sv
module mstlb_store
    import mstlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  tag_t               wr_tag,
    input  tte_t               wr_tte,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [CTX_W-1:0]   lk_ctx,
    output logic [ENTRIES-1:0] match_vec,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [1:0]         rd_size,
    output logic               rd_priv,
    output logic               rd_writable,
    output logic               rd_side_eff,
    output logic               rd_nfo,
    output logic [PPN_W-1:0]   rd_ppn,
    output logic               rd_used,
    input  logic               use_set,
    input  logic [IDX_W-1:0]   use_idx
);

    tag_t               tag_q [ENTRIES];
    tte_t               tte_q [ENTRIES];
    logic [ENTRIES-1:0] used_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                tte_q[i] <= '0;
            end
            used_q <= '0;
        end else begin
            if (use_set) used_q[use_idx] <= 1'b1;
            if (wr_en) begin
                tag_q[wr_idx]  <= wr_tag;
                tte_q[wr_idx]  <= wr_tte;
                used_q[wr_idx] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [VPN_W-1:0] m;
        logic             page_eq;
        logic             ctx_ok;
        assign m            = vpn_mask(tte_q[g].size);
        assign page_eq      = ((tag_q[g].vpn ^ lk_vpn) & m) == '0;
        assign ctx_ok       = tte_q[g].global || (tag_q[g].ctx == lk_ctx);
        assign match_vec[g] = tte_q[g].valid && page_eq && ctx_ok;
    end

    assign rd_size     = tte_q[rd_idx].size;
    assign rd_priv     = tte_q[rd_idx].priv;
    assign rd_writable = tte_q[rd_idx].writable;
    assign rd_side_eff = tte_q[rd_idx].side_eff;
    assign rd_nfo      = tte_q[rd_idx].nfo;
    assign rd_ppn      = tte_q[rd_idx].ppn;
    assign rd_used     = used_q[rd_idx];

    // R8: installing an entry leaves its used mark clear
    p_install_clears_used_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !used_q[$past(wr_idx)]);

endmodule

// File: rtl/mstlb_pick.sv
module mstlb_pick #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] match_vec,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) idx = IDX_W'(i);
        end
    end

    assign any = |match_vec;

    // R4: chosen entry matches and no lower index matches
    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (rst)
        any |-> (match_vec[idx] &&
                 ((match_vec & ((ENTRIES'(1) << idx) - ENTRIES'(1))) == '0)));

endmodule

// File: rtl/mstlb_check.sv
module mstlb_check
    import mstlb_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       user,
    input  logic       pg_priv,
    input  logic       pg_writable,
    input  logic       pg_side_eff,
    input  logic       pg_nfo,
    output flt_t       flt,
    output logic       dfault,
    output logic       prot
);

    logic is_nf;
    logic is_store;

    assign is_nf    = (kind == ACC_NFLOAD);
    assign is_store = (kind == ACC_STORE);

    always_comb begin
        flt.priv_f = pg_priv && user;
        flt.nfe_f  = is_nf && pg_side_eff;
        flt.nfo_f  = !is_nf && pg_nfo;
    end

    assign dfault = flt.priv_f | flt.nfe_f | flt.nfo_f;
    assign prot   = !dfault && is_store && !pg_writable;

endmodule

// File: rtl/mstlb_top.sv
module mstlb_top
    import mstlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [VA_W-1:PG_SHIFT] wr_vpn,
    input  logic [CTX_W-1:0]    wr_ctx,
    input  logic                wr_valid,
    input  logic                wr_global,
    input  logic [1:0]          wr_size,
    input  logic                wr_priv,
    input  logic                wr_writable,
    input  logic                wr_side_effect,
    input  logic                wr_nofault_only,
    input  logic [PA_W-1:PG_SHIFT] wr_ppn,
    input  logic [CTX_W-1:0]    primary_ctx,
    input  logic [CTX_W-1:0]    secondary_ctx,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_va,
    input  logic [1:0]          req_kind,
    input  logic [1:0]          req_ctx_sel,
    input  logic                req_user,
    input  logic                req_priv_mode,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_miss,
    output logic                rsp_dfault,
    output logic                rsp_prot,
    output logic [PA_W-1:0]     rsp_pa,
    output logic                rsp_writable,
    output logic                rsp_first_use,
    output logic [9:0]          fault_status,
    output logic [VA_W-1:0]     fault_addr,
    output logic [VA_W-1:0]     tag_access
);

    // lookup context
    ctx_type_e        ctype;
    logic [CTX_W-1:0] lk_ctx;
    logic [VPN_W-1:0] lk_vpn;

    assign ctype  = sel_to_type(req_ctx_sel);
    assign lk_vpn = req_va[VA_W-1:PG_SHIFT];
    always_comb begin
        case (ctype)
            CT_PRIMARY:   lk_ctx = primary_ctx;
            CT_SECONDARY: lk_ctx = secondary_ctx;
            default:      lk_ctx = '0;
        endcase
    end

    // storage and match
    tag_t               wr_tag;
    tte_t               wr_tte;
    logic [ENTRIES-1:0] match_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic               any_hit;
    logic [1:0]         e_size;
    logic               e_priv, e_writable, e_side_eff, e_nfo, e_used;
    logic [PPN_W-1:0]   e_ppn;
    logic               use_set;

    assign wr_tag = '{vpn: wr_vpn, ctx: wr_ctx};
    assign wr_tte = '{valid: wr_valid, global: wr_global, size: wr_size,
                      priv: wr_priv, writable: wr_writable,
                      side_eff: wr_side_effect, nfo: wr_nofault_only,
                      ppn: wr_ppn};

    mstlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tte(wr_tte),
        .lk_vpn(lk_vpn), .lk_ctx(lk_ctx), .match_vec(match_vec),
        .rd_idx(hit_idx), .rd_size(e_size), .rd_priv(e_priv),
        .rd_writable(e_writable), .rd_side_eff(e_side_eff), .rd_nfo(e_nfo),
        .rd_ppn(e_ppn), .rd_used(e_used),
        .use_set(use_set), .use_idx(hit_idx)
    );

    mstlb_pick #(.ENTRIES(ENTRIES)) u_pick (
        .clk(clk), .rst(rst), .match_vec(match_vec),
        .any(any_hit), .idx(hit_idx)
    );

    // access rights
    flt_t flt;
    logic dfault, prot;

    mstlb_check u_check (
        .kind(req_kind), .user(req_user),
        .pg_priv(e_priv), .pg_writable(e_writable),
        .pg_side_eff(e_side_eff), .pg_nfo(e_nfo),
        .flt(flt), .dfault(dfault), .prot(prot)
    );

    // outcome
    res_e             res_d;
    logic [PPN_W-1:0] pmask;
    logic [PPN_W-1:0] ppn_d;
    fsr_t             fsr_q, fsr_d;

    always_comb begin
        if (!any_hit)    res_d = RES_MISS;
        else if (dfault) res_d = RES_DFAULT;
        else if (prot)   res_d = RES_PROT;
        else             res_d = RES_HIT;
    end

    assign pmask   = ppn_mask(e_size);
    assign ppn_d   = (e_ppn & pmask) | (req_va[PA_W-1:PG_SHIFT] & ~pmask);
    assign use_set = req_valid && (res_d == RES_HIT);

    always_comb begin
        fsr_d           = '0;
        fsr_d.nfo_f     = flt.nfo_f;
        fsr_d.nfe_f     = flt.nfe_f;
        fsr_d.priv_f    = flt.priv_f;
        fsr_d.priv_mode = req_priv_mode;
        fsr_d.ctx_type  = ctype;
        fsr_d.nf        = (req_kind == ACC_NFLOAD);
        fsr_d.wr        = (req_kind == ACC_STORE);
        fsr_d.ovf       = fsr_q.valid;
        fsr_d.valid     = 1'b1;
    end

    // response registers
    logic             rv_q;
    res_e             res_q;
    logic [PPN_W-1:0] ppn_q;
    logic             wok_q, first_q;
    logic [VA_W-1:0]  far_q, tacc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q    <= 1'b0;
            res_q   <= RES_MISS;
            ppn_q   <= '0;
            wok_q   <= 1'b0;
            first_q <= 1'b0;
            fsr_q   <= '0;
            far_q   <= '0;
            tacc_q  <= '0;
        end else begin
            rv_q <= req_valid;
            if (req_valid) begin
                res_q   <= res_d;
                ppn_q   <= (res_d == RES_HIT) ? ppn_d : '0;
                wok_q   <= (res_d == RES_HIT) && e_writable;
                first_q <= (res_d == RES_HIT) && !e_used;
                if (res_d == RES_DFAULT || res_d == RES_PROT) begin
                    fsr_q <= fsr_d;
                    far_q <= req_va;
                end
                if (res_d != RES_HIT) tacc_q <= {lk_vpn, lk_ctx};
            end
        end
    end

    assign rsp_valid     = rv_q;
    assign rsp_hit       = rv_q && (res_q == RES_HIT);
    assign rsp_miss      = rv_q && (res_q == RES_MISS);
    assign rsp_dfault    = rv_q && (res_q == RES_DFAULT);
    assign rsp_prot      = rv_q && (res_q == RES_PROT);
    assign rsp_pa        = {ppn_q, {PG_SHIFT{1'b0}}};
    assign rsp_writable  = wok_q;
    assign rsp_first_use = first_q;
    assign fault_status  = fsr_q;
    assign fault_addr    = far_q;
    assign tag_access    = tacc_q;

    // R12: one response exactly one cycle after each request
    p_rsp_follows_req_r12: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_spurious_rsp_r12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R11: a miss keeps status and fault address
    p_miss_keeps_status_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> ($stable(fault_status) && $stable(fault_addr)));

    // R9: overflow when status was still valid
    p_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        ((rsp_dfault || rsp_prot) && $past(fault_status[0])) |-> fault_status[1]);

    // R6: a data fault always records at least one cause
    p_dfault_cause_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_dfault |-> (fault_status[0] && (fault_status[9:7] != 3'b000)));

    // R7: protection faults record no data-fault cause
    p_prot_clean_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_prot |-> (fault_status[9:7] == 3'b000 && fault_status[2]));

endmodule

// File: tb/sim_mstlb_top.sv
`timescale 1ns/1ps
module sim_mstlb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:13] wr_vpn = '0;
    logic [12:0] wr_ctx = '0;
    logic        wr_valid = 1'b0, wr_global = 1'b0;
    logic [1:0]  wr_size = '0;
    logic        wr_priv = 1'b0, wr_writable = 1'b0;
    logic        wr_side_effect = 1'b0, wr_nofault_only = 1'b0;
    logic [40:13] wr_ppn = '0;
    logic [12:0] primary_ctx = 13'h0123;
    logic [12:0] secondary_ctx = 13'h0456;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_kind = '0, req_ctx_sel = '0;
    logic        req_user = 1'b0, req_priv_mode = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_dfault, rsp_prot;
    logic [40:0] rsp_pa;
    logic        rsp_writable, rsp_first_use;
    logic [9:0]  fault_status;
    logic [63:0] fault_addr, tag_access;

    always #4 clk = ~clk;

    mstlb_top u0 (.*);

    typedef struct {
        logic [3:0]  res;      // {prot,dfault,miss,hit}
        logic [40:0] pa;
        logic        wok;
        logic        first;
        logic [9:0]  fsr;
        logic [63:0] far;
        logic [63:0] tacc;
        string       req;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic        done = 1'b0;
    logic [9:0]  m_fsr = '0;
    logic [63:0] m_far = '0;
    logic [63:0] m_tag = '0;

    localparam logic [1:0] E_HIT = 2'd0, E_MISS = 2'd1, E_DF = 2'd2, E_PROT = 2'd3;

    task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic install(input int idx, input logic [63:0] va, input logic [12:0] ctx,
                           input logic v, input logic g, input logic [1:0] sz,
                           input logic pv, input logic w, input logic se, input logic nfo,
                           input logic [40:0] pa);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn = va[63:13]; wr_ctx = ctx;
        wr_valid = v; wr_global = g; wr_size = sz; wr_priv = pv;
        wr_writable = w; wr_side_effect = se; wr_nofault_only = nfo;
        wr_ppn = pa[40:13];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: computes expectations from the requirements and queues them
    task automatic lookup(input logic [63:0] va, input logic [1:0] kind, input logic [1:0] sel,
                          input logic user, input logic pmode, input logic [1:0] eres,
                          input logic [40:0] epa, input logic ewok, input logic efirst,
                          input logic [2:0] eflt, input string req);
        exp_t       e;
        logic [12:0] ctx;
        logic [1:0]  ct;
        ctx = (sel == 2'd0) ? primary_ctx : (sel == 2'd1) ? secondary_ctx : 13'h0;
        ct  = (sel == 2'd0) ? 2'd0 : (sel == 2'd1) ? 2'd1 : 2'd2;
        if (eres == E_DF || eres == E_PROT) begin
            m_fsr = {eflt, pmode, ct, (kind == 2'd2), (kind == 2'd1), m_fsr[0], 1'b1};
            m_far = va;
        end
        if (eres != E_HIT) m_tag = {va[63:13], ctx};
        e.res   = 4'b0001 << eres;
        e.pa    = epa;
        e.wok   = ewok;
        e.first = efirst;
        e.fsr   = m_fsr;
        e.far   = m_far;
        e.tacc  = m_tag;
        e.req   = req;
        q.push_back(e);
        req_valid = 1'b1; req_va = va; req_kind = kind; req_ctx_sel = sel;
        req_user = user; req_priv_mode = pmode;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q.size() == 0) begin
                chk("R12", 256'(1), 256'(0));
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.req, " result"}, 256'({rsp_prot, rsp_dfault, rsp_miss, rsp_hit}), 256'(e.res));
                chk({e.req, " pa"}, 256'(rsp_pa), 256'(e.pa));
                chk({e.req, " R8 rights/use"}, 256'({rsp_writable, rsp_first_use}), 256'({e.wok, e.first}));
                chk({e.req, " R9 status"}, 256'(fault_status), 256'(e.fsr));
                chk({e.req, " R9 address"}, 256'(fault_addr), 256'(e.far));
                chk({e.req, " R10 tag"}, 256'(tag_access), 256'(e.tacc));
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset outputs", 256'({rsp_valid, fault_status, fault_addr, tag_access}), 256'(0));

        // R11 empty buffer misses
        lookup(64'hDEAD_B000, 2'd0, 2'd0, 1'b0, 1'b0, E_MISS, '0, 0, 0, 3'b000, "R11");

        install(5,  64'h4000_0000,     13'h0123, 1, 0, 2'd0, 0, 1, 0, 0, 41'h1_2345_6000);
        install(10, 64'h12_0040_0000,  13'h0000, 1, 1, 2'd3, 0, 0, 0, 0, 41'h0_ABC0_0000);
        install(20, 64'h7FFF_0000,     13'h0456, 1, 0, 2'd1, 1, 1, 0, 0, 41'h1_0000_0000);
        install(30, 64'h0800_0000,     13'h0123, 1, 0, 2'd2, 1, 1, 1, 1, 41'h0_2008_0000);
        install(40, 64'h9000_0000,     13'h0000, 1, 1, 2'd0, 0, 1, 0, 0, 41'h0_5000_0000);
        install(3,  64'h9000_0000,     13'h0000, 1, 1, 2'd0, 0, 0, 0, 0, 41'h0_3000_0000);
        install(50, 64'hA000_0000,     13'h0000, 1, 1, 2'd0, 1, 0, 0, 0, 41'h0_7000_0000);

        // R3 8 KB hit, first use
        lookup(64'h4000_0ABC, 2'd0, 2'd0, 1'b1, 1'b0, E_HIT, 41'h1_2345_6000, 1, 1, 3'b000, "R3");
        // R8 second use reports not first
        lookup(64'h4000_0ABC, 2'd1, 2'd0, 1'b1, 1'b0, E_HIT, 41'h1_2345_6000, 1, 0, 3'b000, "R8");
        // R2 context mismatch
        lookup(64'h4000_0ABC, 2'd0, 2'd1, 1'b1, 1'b0, E_MISS, '0, 0, 0, 3'b000, "R2");
        // R1 next 8 KB page misses
        lookup(64'h4000_2000, 2'd0, 2'd0, 1'b1, 1'b0, E_MISS, '0, 0, 0, 3'b000, "R1");
        // R1 4 MB global page in nucleus
        lookup(64'h12_0055_5555, 2'd0, 2'd2, 1'b0, 1'b0, E_HIT, 41'h0_ABD5_4000, 0, 1, 3'b000, "R1");
        // R2 global ignores context
        lookup(64'h12_0055_5555, 2'd0, 2'd1, 1'b0, 1'b0, E_HIT, 41'h0_ABD5_4000, 0, 0, 3'b000, "R2");
        // R7 store to read-only page
        lookup(64'h12_0055_5555, 2'd1, 2'd2, 1'b0, 1'b1, E_PROT, '0, 0, 0, 3'b000, "R7");
        // R5 user on privileged page, overflow now set
        lookup(64'h7FFF_2000, 2'd0, 2'd1, 1'b1, 1'b0, E_DF, '0, 0, 0, 3'b001, "R5");
        // R1 64 KB page offset
        lookup(64'h7FFF_E000, 2'd0, 2'd1, 1'b0, 1'b0, E_HIT, 41'h1_0000_E000, 1, 1, 3'b000, "R1");
        // R11 miss below page keeps status
        lookup(64'h7FFE_E000, 2'd0, 2'd1, 1'b0, 1'b0, E_MISS, '0, 0, 0, 3'b000, "R11");
        // R6 two causes at once
        lookup(64'h0807_FFFF, 2'd2, 2'd0, 1'b1, 1'b0, E_DF, '0, 0, 0, 3'b011, "R6");
        // R6 no-fault-only on normal load
        lookup(64'h0800_0000, 2'd0, 2'd0, 1'b0, 1'b1, E_DF, '0, 0, 0, 3'b100, "R6");
        // R6 non-faulting load to side-effect page
        lookup(64'h0800_4000, 2'd2, 2'd0, 1'b0, 1'b1, E_DF, '0, 0, 0, 3'b010, "R6");
        // R1 just past 512 KB page
        lookup(64'h0808_0000, 2'd0, 2'd0, 1'b0, 1'b0, E_MISS, '0, 0, 0, 3'b000, "R1");
        // R7 data fault takes precedence over protection
        lookup(64'hA000_0000, 2'd1, 2'd0, 1'b1, 1'b0, E_DF, '0, 0, 0, 3'b001, "R7");
        // R4 lowest index wins
        lookup(64'h9000_0100, 2'd0, 2'd2, 1'b0, 1'b0, E_HIT, 41'h0_3000_0000, 0, 1, 3'b000, "R4");
        install(3, 64'h9000_0000, 13'h0000, 0, 1, 2'd0, 0, 0, 0, 0, 41'h0_3000_0000);
        lookup(64'h9000_0100, 2'd0, 2'd2, 1'b0, 1'b0, E_HIT, 41'h0_5000_0000, 1, 1, 3'b000, "R4");
        // R8 reinstall clears used mark
        install(5, 64'h4000_0000, 13'h0123, 1, 0, 2'd0, 0, 1, 0, 0, 41'h1_2345_6000);
        lookup(64'h4000_0ABC, 2'd0, 2'd0, 1'b1, 1'b0, E_HIT, 41'h1_2345_6000, 1, 1, 3'b000, "R8");
        // R2 selector 3 means nucleus
        lookup(64'h4000_0000, 2'd0, 2'd3, 1'b0, 1'b0, E_MISS, '0, 0, 0, 3'b000, "R2");

        repeat (3) @(negedge clk);
        chk("R12 all responses seen", 256'(q.size()), 256'(0));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R12 watchdog got=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule